// File: doc/BRIEF.md
# Hue-Saturation 2D Histogram Engine

The engine watches a stream of 32-bit pixels carrying alpha, hue, saturation and value channels, one byte each. For every pixel inside a programmable rectangle, after optional power-of-two decimation on each axis, it finds which of six programmable hue ranges the pixel belongs to. It then bumps one of 32 saturation counters for that range, so the histogram holds 192 counters in all. The same pixels also feed running statistics of the value channel: the largest value, the smallest value and a saturating sum.

Software programs the rectangle, the decimation codes and the twelve hue limits through a simple word-wide register port. It clears the statistics with a command before each frame and reads the results back after the frame. The results region starts with the extremes word, then the sum word, then the counters with the hue range as the slow index and the saturation bin as the fast index. The pixel port uses a valid/ready handshake. The engine never applies back-pressure: a beat is taken on every cycle where `in_valid` is high, so a producer may treat `in_ready` as a permanent grant. Data and markers are sampled only on taken beats.

Top module: `hsv_hist2d`

## Requirements
- R1: `in_ready` is high in every cycle after reset; a beat is taken exactly when `in_valid` is high.
- R2: After reset and after a clear command, every counter and the sum read 0, and the extremes word reads 0x000000FF (largest value 0, smallest value 255).
- R3: A taken beat with `in_sof` high is at column 0, row 0. The beat after one with `in_eol` high starts column 0 of the next row; any other beat advances the column by one. A pixel is kept only if its column lies in [X origin, X origin + width) and its row lies in [Y origin, Y origin + height).
- R4: With horizontal decimation code h, a pixel inside the window is kept only if (column − X origin) is a multiple of 2^h; the vertical code v applies the same rule to rows. Code 0 keeps every pixel.
- R5: Pixel layout is alpha [31:24], hue [23:16], saturation [15:8], value [7:0]. Hue range k matches when lower ≤ hue ≤ upper; if lower > upper the range wraps and matches hue ≥ lower or hue ≤ upper.
- R6: When several ranges match, the lowest-numbered one is used. A kept pixel that matches no range bumps no counter but still updates the value statistics.
- R7: A kept, matched pixel bumps the counter of its range at bin saturation[7:3]. A counter stops at 2^COUNT_W − 1.
- R8: The extremes word holds the largest kept value at bits [15:8] and the smallest at bits [7:0], with zeros above.
- R9: The sum adds the value of every kept pixel and stops at 2^SUM_W − 1.
- R10: A read at address A with `reg_re` high shows on `reg_rdata` one cycle later, and `reg_rdata` holds when `reg_re` is low. Results sit at RES_BASE = 2^(ADDR_W−1): extremes at RES_BASE, sum at RES_BASE+1, and the counter for range k, bin b at RES_BASE+2+32k+b. Addresses past the last counter read 0.
- R11: Register map: address 0 bit 0 = clear command; 1 = origin (X at [COORD_W−1:0], Y at [16+COORD_W−1:16]); 2 = size (width and height in the same fields); 3 = decimation (h at [RATIO_W−1:0], v at [8+RATIO_W−1:8]); 4+k = range k (lower [7:0], upper [15:8]). Addresses 1 to 9 read back as written. A clear in the same cycle as a taken beat wins, and that beat is discarded.
- R12: Cycles with `in_valid` low change no counter or statistic, whatever the data and marker inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel beat valid |
| in_ready | output | 1 | Pixel beat accepted (always high) |
| in_data | input | 32 | Pixel: alpha, hue, saturation, value |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_eol | input | 1 | Beat is the last pixel of a line |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_re` |

## Verification
The assertions assume well-formed traffic. Markers carry meaning only on beats where `in_valid` is high, a clear is issued only between frames or deliberately alongside a beat, and register writes change no setting while a frame is running. The stimulus follows this: each frame starts with `in_sof`, closes each row with `in_eol`, fills idle cycles with junk data and markers, and changes settings only between frames. One clear is issued in the same cycle as a beat on purpose. The statistics properties depend only on the strobes, so they hold for any pixel content, including the saturating cases.

// File: rtl/hh_pkg.sv
package hh_pkg;
  typedef logic [7:0] chan_t;

  typedef struct packed {
    chan_t alpha;
    chan_t hue;
    chan_t sat;
    chan_t val;
  } ahsv_t;

  typedef struct packed {
    chan_t upper;
    chan_t lower;
  } hue_span_t;
endpackage

// File: rtl/hh_window.sv
module hh_window #(
  parameter int COORD_W = 12,
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic               sof,
  input  logic               eol,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] org_y,
  input  logic [COORD_W-1:0] ext_w,
  input  logic [COORD_W-1:0] ext_h,
  input  logic [RATIO_W-1:0] step_h,
  input  logic [RATIO_W-1:0] step_v,
  output logic               keep
);
  localparam int RW = COORD_W + 1;

  logic [COORD_W-1:0] x_q, y_q, cur_x, cur_y;
  logic [RW-1:0]      rel_x, rel_y, mask_h, mask_v;
  logic               in_x, in_y;

  assign cur_x = sof ? '0 : x_q;
  assign cur_y = sof ? '0 : y_q;

  assign rel_x  = {1'b0, cur_x} - {1'b0, org_x};
  assign rel_y  = {1'b0, cur_y} - {1'b0, org_y};
  assign mask_h = ~({RW{1'b1}} << step_h);
  assign mask_v = ~({RW{1'b1}} << step_v);

  assign in_x = (cur_x >= org_x) && (rel_x < {1'b0, ext_w});
  assign in_y = (cur_y >= org_y) && (rel_y < {1'b0, ext_h});

  assign keep = in_x && in_y && ((rel_x & mask_h) == '0) && ((rel_y & mask_v) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (fire) begin
      if (eol) begin
        x_q <= '0;
        y_q <= cur_y + 1'b1;
      end else begin
        x_q <= cur_x + 1'b1;
        y_q <= cur_y;
      end
    end
  end
endmodule

// File: rtl/hh_classify.sv
module hh_classify
  import hh_pkg::*;
#(
  parameter int NUM_AREAS = 6,
  localparam int AREA_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
  input  chan_t                        hue,
  input  hue_span_t [NUM_AREAS-1:0]    spans,
  output logic      [NUM_AREAS-1:0]    grant,
  output logic                         hit,
  output logic      [AREA_W-1:0]       area
);
  logic [NUM_AREAS-1:0] match;

  for (genvar k = 0; k < NUM_AREAS; k++) begin : g_match
    assign match[k] = (spans[k].lower <= spans[k].upper)
                    ? (hue >= spans[k].lower && hue <= spans[k].upper)
                    : (hue >= spans[k].lower || hue <= spans[k].upper);
  end

  always_comb begin
    grant = '0;
    area  = '0;
    hit   = 1'b0;
    for (int k = 0; k < NUM_AREAS; k++) begin
      if (match[k] && !hit) begin
        grant[k] = 1'b1;
        area     = AREA_W'(k);
        hit      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hh_accum.sv
module hh_accum #(
  parameter int NUM_AREAS = 6,
  parameter int NUM_BINS  = 32,
  parameter int COUNT_W   = 16,
  parameter int SUM_W     = 32,
  localparam int AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1,
  localparam int BIN_W     = $clog2(NUM_BINS),
  localparam int NUM_CELLS = NUM_AREAS * NUM_BINS,
  localparam int CELL_W    = $clog2(NUM_CELLS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               take,
  input  logic               hit,
  input  logic [AREA_W-1:0]  area,
  input  logic [BIN_W-1:0]   bin,
  input  logic [7:0]         val,
  input  logic [CELL_W-1:0]  rd_cell,
  output logic [COUNT_W-1:0] rd_count,
  output logic [7:0]         max_q,
  output logic [7:0]         min_q,
  output logic [SUM_W-1:0]   sum_q
);
  logic [COUNT_W-1:0] cnt [NUM_CELLS];
  logic [CELL_W-1:0]  cell_idx;
  logic [SUM_W:0]     sum_nxt;

  assign cell_idx = CELL_W'(area) * CELL_W'(NUM_BINS) + CELL_W'(bin);

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    logic bump;
    assign bump = take && hit && (cell_idx == CELL_W'(c));
    always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt[c] <= '0;
      else if (bump && (cnt[c] != '1)) cnt[c] <= cnt[c] + 1'b1;
    end
  end

  assign rd_count = (rd_cell < CELL_W'(NUM_CELLS)) ? cnt[rd_cell] : '0;

  assign sum_nxt = {1'b0, sum_q} + (SUM_W + 1)'(val);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sum_q <= '0;
      max_q <= 8'h00;
      min_q <= 8'hFF;
    end else if (take) begin
      sum_q <= sum_nxt[SUM_W] ? '1 : sum_nxt[SUM_W-1:0];
      if (val > max_q) max_q <= val;
      if (val < min_q) min_q <= val;
    end
  end
endmodule

// File: rtl/hsv_hist2d.sv
module hsv_hist2d
  import hh_pkg::*;
#(
  parameter int COORD_W   = 12,
  parameter int RATIO_W   = 2,
  parameter int NUM_AREAS = 6,
  parameter int NUM_BINS  = 32,
  parameter int COUNT_W   = 16,
  parameter int SUM_W     = 32,
  parameter int ADDR_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic              in_sof,
  input  logic              in_eol,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1;
  localparam int BIN_W     = $clog2(NUM_BINS);
  localparam int NUM_CELLS = NUM_AREAS * NUM_BINS;
  localparam int CELL_W    = $clog2(NUM_CELLS + 1);
  localparam int RES_BASE  = 1 << (ADDR_W - 1);
  localparam int HUE_BASE  = 4;

  logic [COORD_W-1:0]       org_x, org_y, ext_w, ext_h;
  logic [RATIO_W-1:0]       step_h, step_v;
  hue_span_t [NUM_AREAS-1:0] spans;

  ahsv_t                px;
  logic                 fire, keep, take, clear, hit;
  logic [NUM_AREAS-1:0] grant;
  logic [AREA_W-1:0]    area;
  logic [7:0]           px_val, max_q, min_q;
  logic [SUM_W-1:0]     sum_q;
  logic [COUNT_W-1:0]   rd_count;
  logic [ADDR_W-1:0]    rd_idx, cell_off;
  logic [31:0]          rd_word, rdata_q;

  assign in_ready = 1'b1;
  assign fire     = in_valid && in_ready;
  assign px       = ahsv_t'(in_data);
  assign px_val   = px.val;
  assign clear    = reg_we && (reg_addr == '0) && reg_wdata[0];
  assign take     = fire && keep && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      org_x  <= '0;
      org_y  <= '0;
      ext_w  <= '0;
      ext_h  <= '0;
      step_h <= '0;
      step_v <= '0;
      spans  <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(1)) begin
        org_x <= reg_wdata[COORD_W-1:0];
        org_y <= reg_wdata[16 +: COORD_W];
      end
      if (reg_addr == ADDR_W'(2)) begin
        ext_w <= reg_wdata[COORD_W-1:0];
        ext_h <= reg_wdata[16 +: COORD_W];
      end
      if (reg_addr == ADDR_W'(3)) begin
        step_h <= reg_wdata[RATIO_W-1:0];
        step_v <= reg_wdata[8 +: RATIO_W];
      end
      for (int k = 0; k < NUM_AREAS; k++) begin
        if (reg_addr == ADDR_W'(HUE_BASE + k)) spans[k] <= hue_span_t'(reg_wdata[15:0]);
      end
    end
  end

  hh_window #(.COORD_W(COORD_W), .RATIO_W(RATIO_W)) u_window (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sof(in_sof), .eol(in_eol),
    .org_x(org_x), .org_y(org_y), .ext_w(ext_w), .ext_h(ext_h),
    .step_h(step_h), .step_v(step_v), .keep(keep)
  );

  hh_classify #(.NUM_AREAS(NUM_AREAS)) u_classify (
    .hue(px.hue), .spans(spans), .grant(grant), .hit(hit), .area(area)
  );

  assign rd_idx   = reg_addr - ADDR_W'(RES_BASE);
  assign cell_off = rd_idx - ADDR_W'(2);

  hh_accum #(
    .NUM_AREAS(NUM_AREAS), .NUM_BINS(NUM_BINS),
    .COUNT_W(COUNT_W), .SUM_W(SUM_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(clear), .take(take), .hit(hit),
    .area(area), .bin(px.sat[7 -: BIN_W]), .val(px_val),
    .rd_cell(cell_off[CELL_W-1:0]), .rd_count(rd_count),
    .max_q(max_q), .min_q(min_q), .sum_q(sum_q)
  );

  always_comb begin
    rd_word = '0;
    if (reg_addr >= ADDR_W'(RES_BASE)) begin
      if (rd_idx == '0) begin
        rd_word[15:8] = max_q;
        rd_word[7:0]  = min_q;
      end else if (rd_idx == ADDR_W'(1)) begin
        rd_word[SUM_W-1:0] = sum_q;
      end else if (cell_off < ADDR_W'(NUM_CELLS)) begin
        rd_word[COUNT_W-1:0] = rd_count;
      end
    end else if (reg_addr == ADDR_W'(1)) begin
      rd_word[COORD_W-1:0]   = org_x;
      rd_word[16 +: COORD_W] = org_y;
    end else if (reg_addr == ADDR_W'(2)) begin
      rd_word[COORD_W-1:0]   = ext_w;
      rd_word[16 +: COORD_W] = ext_h;
    end else if (reg_addr == ADDR_W'(3)) begin
      rd_word[RATIO_W-1:0]  = step_h;
      rd_word[8 +: RATIO_W] = step_v;
    end else begin
      for (int k = 0; k < NUM_AREAS; k++) begin
        if (reg_addr == ADDR_W'(HUE_BASE + k)) rd_word[15:0] = spans[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_re) rdata_q <= rd_word;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/hh_checker.sv
module hh_checker #(
  parameter int NUM_AREAS = 6,
  parameter int SUM_W     = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clear,
  input logic                 take,
  input logic                 hit,
  input logic [NUM_AREAS-1:0] grant,
  input logic [7:0]           px_val,
  input logic [7:0]           max_q,
  input logic [7:0]           min_q,
  input logic [SUM_W-1:0]     sum_q,
  input logic                 reg_re,
  input logic [31:0]          reg_rdata
);
  a_r2_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sum_q == '0) && (max_q == 8'h00) && (min_q == 8'hFF));

  a_r6_one_area: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (hit == (grant != '0)));

  a_r8_extremes_cover: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (max_q >= $past(px_val)) && (min_q <= $past(px_val)));

  a_r9_sum_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> sum_q >= $past(sum_q));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(reg_rdata));

  a_r12_idle_stats: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clear) |=> $stable(sum_q) && $stable(max_q) && $stable(min_q));
endmodule

bind hsv_hist2d hh_checker #(.NUM_AREAS(NUM_AREAS), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .take(take), .hit(hit),
  .grant(grant), .px_val(px_val), .max_q(max_q), .min_q(min_q),
  .sum_q(sum_q), .reg_re(reg_re), .reg_rdata(reg_rdata)
);

// File: tb/hsv_hist2d_tb.sv
module hsv_hist2d_tb;
  localparam int COORD_W = 12;
  localparam int RATIO_W = 2;
  localparam int NA      = 6;
  localparam int NB      = 32;
  localparam int COUNT_W = 5;
  localparam int SUM_W   = 12;
  localparam int ADDR_W  = 9;
  localparam int RES     = 1 << (ADDR_W - 1);
  localparam int CMAX    = (1 << COUNT_W) - 1;
  localparam int SMAX    = (1 << SUM_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_sof = 1'b0, in_eol = 1'b0;
  logic [31:0] in_data = '0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  always #2.5 clk = ~clk;

  hsv_hist2d #(
    .COORD_W(COORD_W), .RATIO_W(RATIO_W), .NUM_AREAS(NA), .NUM_BINS(NB),
    .COUNT_W(COUNT_W), .SUM_W(SUM_W), .ADDR_W(ADDR_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R2";

  // reference model state
  int m_cnt [NA][NB];
  int m_sum, m_max, m_min, m_px, m_py;
  int m_ox, m_oy, m_w, m_h, m_rh, m_rv;
  int m_lo [NA];
  int m_up [NA];
  logic [31:0] exp_rd;
  bit rd_pend = 0;
  string rd_tag;

  function automatic int area_of(int hue);
    for (int k = 0; k < NA; k++) begin
      if (m_lo[k] <= m_up[k] ? (hue >= m_lo[k] && hue <= m_up[k])
                             : (hue >= m_lo[k] || hue <= m_up[k])) return k;
    end
    return -1;
  endfunction

  function automatic logic [31:0] model_read(int a);
    int i;
    if (a >= RES) begin
      i = a - RES;
      if (i == 0) return 32'(m_max * 256 + m_min);
      if (i == 1) return 32'(m_sum);
      if (i - 2 < NA * NB) return 32'(m_cnt[(i - 2) / NB][(i - 2) % NB]);
      return 32'd0;
    end
    if (a == 1) return 32'(m_oy * 65536 + m_ox);
    if (a == 2) return 32'(m_h * 65536 + m_w);
    if (a == 3) return 32'(m_rv * 256 + m_rh);
    if (a >= 4 && a < 4 + NA) return 32'(m_up[a - 4] * 256 + m_lo[a - 4]);
    return 32'd0;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < NA; k++)
      for (int b = 0; b < NB; b++) m_cnt[k][b] = 0;
    m_sum = 0; m_max = 0; m_min = 255;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
      m_px = 0; m_py = 0; m_ox = 0; m_oy = 0; m_w = 0; m_h = 0; m_rh = 0; m_rv = 0;
      for (int k = 0; k < NA; k++) begin m_lo[k] = 0; m_up[k] = 0; end
      rd_pend <= 0;
    end else begin
      bit clr;
      if (reg_re) begin
        exp_rd <= model_read(int'(reg_addr));
        rd_tag <= tag;
      end
      rd_pend <= reg_re;
      clr = reg_we && reg_addr == 0 && reg_wdata[0];
      if (in_valid) begin
        int cx, cy, hue, sat, val, ar, dx, dy;
        cx = in_sof ? 0 : m_px;
        cy = in_sof ? 0 : m_py;
        if (in_eol) begin m_px = 0; m_py = cy + 1; end
        else begin m_px = cx + 1; m_py = cy; end
        hue = int'(in_data[23:16]); sat = int'(in_data[15:8]); val = int'(in_data[7:0]);
        dx = cx - m_ox; dy = cy - m_oy;
        if (!clr && dx >= 0 && dx < m_w && dy >= 0 && dy < m_h &&
            dx % (1 << m_rh) == 0 && dy % (1 << m_rv) == 0) begin
          m_sum = (m_sum + val > SMAX) ? SMAX : m_sum + val;
          if (val > m_max) m_max = val;
          if (val < m_min) m_min = val;
          ar = area_of(hue);
          if (ar >= 0 && m_cnt[ar][sat / 8] < CMAX) m_cnt[ar][sat / 8]++;
        end
      end
      if (clr) model_clear();
      if (reg_we) begin
        case (int'(reg_addr))
          1: begin m_ox = int'(reg_wdata[11:0]); m_oy = int'(reg_wdata[27:16]); end
          2: begin m_w = int'(reg_wdata[11:0]); m_h = int'(reg_wdata[27:16]); end
          3: begin m_rh = int'(reg_wdata[1:0]); m_rv = int'(reg_wdata[9:8]); end
          default: if (reg_addr >= 4 && reg_addr < 4 + NA) begin
            m_lo[reg_addr - 4] = int'(reg_wdata[7:0]);
            m_up[reg_addr - 4] = int'(reg_wdata[15:8]);
          end
        endcase
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (in_ready !== 1'b1) begin
        n_bad++;
        $display("FAIL R1 in_ready actual %b expected 1", in_ready);
      end
      if (rd_pend) begin
        n_chk++;
        if (reg_rdata !== exp_rd) begin
          n_bad++;
          $display("FAIL %s rdata actual %h expected %h", rd_tag, reg_rdata, exp_rd);
        end
      end
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = ADDR_W'(a);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic dump_all();
    for (int i = 0; i < NA * NB + 3; i++) rd(RES + i);
  endtask

  task automatic beat(int hue, int sat, int val, bit sof, bit eol);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_eol = eol;
    in_data = {8'hA5, 8'(hue), 8'(sat), 8'(val)};
    if ($urandom_range(0, 3) == 0) begin
      @(negedge clk);
      // idle cycle with junk markers and data (R12)
      in_valid = 1'b0; in_sof = 1'b1; in_eol = 1'b1; in_data = $urandom;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
  endtask

  task automatic frame(int fw, int fh, int mode);
    for (int y = 0; y < fh; y++)
      for (int x = 0; x < fw; x++) begin
        int hue;
        if (mode == 0) hue = $urandom_range(0, 255);
        else begin
          case ((x + 3 * y) % 7)
            0: hue = 250; 1: hue = 10; 2: hue = 50; 3: hue = 25;
            4: hue = 100; 5: hue = 205; default: hue = 240;
          endcase
        end
        beat(hue, $urandom_range(0, 255), $urandom_range(0, 120), x == 0 && y == 0, x == fw - 1);
      end
    idle();
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state, R10 readout map
    tag = "R2 R10";
    dump_all();

    // R11 configuration readback
    tag = "R11";
    wr(1, {4'd0, 12'd1, 4'd0, 12'd2});
    wr(2, {4'd0, 12'd4, 4'd0, 12'd6});
    wr(3, 32'h0);
    wr(4, {16'd0, 8'd30, 8'd0});
    wr(5, {16'd0, 8'd60, 8'd31});
    wr(6, {16'd0, 8'd100, 8'd61});
    wr(7, {16'd0, 8'd150, 8'd101});
    wr(8, {16'd0, 8'd200, 8'd151});
    wr(9, {16'd0, 8'd240, 8'd201});
    for (int a = 1; a < 10; a++) rd(a);

    // R3 window, R5 plain ranges, R7 bins, R8 extremes, R12 idle beats
    frame(10, 6, 0);
    tag = "R3 R5 R7 R8 R12";
    dump_all();

    // R11 clear in the same cycle as a taken beat; R2 cleared state
    @(negedge clk);
    reg_we = 1'b1; reg_addr = '0; reg_wdata = 32'h1;
    in_valid = 1'b1; in_sof = 1'b1; in_eol = 1'b0; in_data = {8'h0, 8'd10, 8'd10, 8'd77};
    @(negedge clk);
    reg_we = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
    tag = "R11 R2";
    dump_all();

    // R4 decimation, R5 wrapping range 0, R6 overlap and unmatched hues
    wr(1, 32'h0);
    wr(2, {4'd0, 12'd6, 4'd0, 12'd8});
    wr(3, {22'd0, 2'd1, 6'd0, 2'd1});
    wr(4, {16'd0, 8'd20, 8'd240});
    wr(5, {16'd0, 8'd50, 8'd30});
    wr(6, {16'd0, 8'd70, 8'd50});
    wr(7, {16'd0, 8'd90, 8'd71});
    wr(8, {16'd0, 8'd100, 8'd100});
    wr(9, {16'd0, 8'd210, 8'd200});
    frame(8, 6, 1);
    tag = "R4 R5 R6 R8";
    dump_all();
    wr(3, {22'd0, 2'd2, 6'd0, 2'd0});
    wr(0, 32'h1);
    frame(8, 6, 1);
    tag = "R4 R6";
    dump_all();

    // R7 counter ceiling, R9 sum ceiling
    wr(0, 32'h1);
    wr(2, {4'd0, 12'd1, 4'd0, 12'd64});
    wr(3, 32'h0);
    for (int i = 0; i < 40; i++) beat(5, 255, 255, i == 0, i == 39);
    idle();
    tag = "R7 R9";
    dump_all();

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule